// File: doc/BRIEF.md
# Three-Wire Nibble Register Access Master

This block runs one register transaction at a time with a serial real-time-clock device over a three-wire link. The link has a clock line, a data line with a separate output enable, and a chip enable. A host asks for a read or a write of a 4-bit register at a 4-bit address. For a write, the block shifts out a command byte and then a data byte. For a read, it shifts out a command byte and then clocks in a response byte, of which only the low nibble is kept. Completion is signalled by a one-cycle `done_o` pulse. Read data is valid on `rdata_o` in that same cycle.

The host uses a start/busy/done handshake. A higher-level sequencer owns the chip enable. Its request is passed straight through to the pin. Time formatting, busy polling and retry policy sit in that sequencer and are not part of this block.

The half-period length is derived from two parameters, the system clock frequency in MHz and the minimum half period in ns: HALF = ceil(HALF_NS * CLK_MHZ / 1000) system cycles, with a floor of 1. The defaults are 250 MHz and 700 ns, which give 175 cycles.

Top module: `trio_nib_master`

## Requirements
- R1: While reset is held and whenever the block is idle: `busy_o` = 0, `done_o` = 0, `sclk_o` = 1, `sdo_oe_o` = 0, and `sclk_oe_o` = 1. `rdata_o` resets to 0.
- R2: `ce_o` equals `ce_req_i` in every cycle, with no register in between.
- R3: `start_i` is accepted only when the block is idle. A `start_i`, or a change of `rd_i`, `addr_i` or `wdata_i`, while busy has no effect on the link waveform or on the result.
- R4: Bytes go out most significant bit first. Each bit is sent in two phases of HALF cycles each. In the first phase, `sclk_o` = 1 and the bit is on `sdo_o`. In the second phase, `sclk_o` = 0 and the bit is still on `sdo_o`.
- R5: A write sends two bytes. The command byte is {0,0,1,0,addr[3:0]}, which is 0x20 OR addr. The data byte is {0,0,0,1,wdata[3:0]}, which is 0x10 OR (wdata AND 0xF).
- R6: A read sends the command byte {0,1,1,0,addr[3:0]}, which is 0x60 OR addr. It then receives 8 bits, MSB first. Each received bit has a HALF-cycle phase with `sclk_o` = 1, followed by a HALF-cycle phase with `sclk_o` = 0. `sdi_i` is sampled at the clock edge that ends the last cycle of the high phase. `rdata_o` takes bits 3:0 of the received byte.
- R7: `sdo_oe_o` rises in the first cycle of bit 7 of each transmitted byte. It stays high through the first cycle after that byte's final rising clock edge, and is low otherwise, including throughout reception.
- R8: Each transmitted byte is followed by a gap phase of HALF cycles with `sclk_o` = 1.
- R9: `done_o` is a single-cycle pulse, and `busy_o` falls in the same cycle. Counted from the first busy cycle, a write is busy for 34*HALF cycles and a read for 33*HALF cycles.
- R10: `rdata_o` changes only in the cycle in which `done_o` ends a read. Writes leave it unchanged.
- R11: HALF = ceil(HALF_NS*CLK_MHZ/1000), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction request, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Nibble to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Nibble from last read |
| ce_req_i | input | 1 | Chip enable request from the sequencer |
| ce_o | output | 1 | Chip enable to the device |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |

## Verification
The hardest thing to pin down from the ports is the exact cycle in which each response bit is sampled. A slave that holds `sdi_i` steady for a whole high phase would hide a sampling point that is off by one or more cycles. The bench therefore drives the correct bit only in the last cycle of each receive high phase, and drives its complement in every other cycle, so any shift in the sampling point corrupts `rdata_o`. Requests raised mid-transaction, with different operands, confirm that the latched operation runs to its end unchanged.

// File: rtl/trio_pkg.sv
package trio_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int BIT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] K_READ = 8'h40;
  localparam logic [BYTE_W-1:0] K_ADDR = 8'h20;
  localparam logic [BYTE_W-1:0] K_DATA = 8'h10;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TXH, PH_TXL, PH_GAP, PH_RXH, PH_RXL
  } phase_e;

  function automatic logic [BYTE_W-1:0] cmd_byte(input logic rd, input logic [NIB_W-1:0] a);
    return {{(BYTE_W-NIB_W){1'b0}}, a} | K_ADDR | (rd ? K_READ : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] n);
    return {{(BYTE_W-NIB_W){1'b0}}, n & {NIB_W{1'b1}}} | K_DATA;
  endfunction
endpackage

// File: rtl/trio_half_timer.sv
module trio_half_timer #(
  parameter int unsigned HALF_CYC = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);

  // R11: every phase lasts exactly HALF_CYC cycles
  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && last_o) |=> first_o);
endmodule

// File: rtl/trio_shifter.sv
module trio_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         in_bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], in_bit_i};
  end
endmodule

// File: rtl/trio_phase_fsm.sv
module trio_phase_fsm
  import trio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [NIB_W-1:0]  addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] q_i,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_val_o,
  output logic              shift_o,
  output phase_e            phase_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NIB_W-1:0]  rdata_o
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

  phase_e            phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic              second_q, rd_q;
  logic [NIB_W-1:0]  nib_q;

  logic take, load_data;
  assign take      = (phase_q == PH_IDLE) && start_i;
  assign load_data = (phase_q == PH_GAP) && last_i && !rd_q && !second_q;

  always_comb begin
    load_o     = take || load_data;
    load_val_o = take ? cmd_byte(rd_i, addr_i) : data_byte(nib_q);
    shift_o    = ((phase_q == PH_TXL) && last_i && (bit_q != '0)) ||
                 ((phase_q == PH_RXH) && last_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      second_q <= 1'b0;
      rd_q     <= 1'b0;
      nib_q    <= '0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q  <= PH_TXH;
          bit_q    <= TOP_BIT;
          second_q <= 1'b0;
          rd_q     <= rd_i;
          nib_q    <= wdata_i;
        end
        PH_TXH: if (last_i) phase_q <= PH_TXL;
        PH_TXL: if (last_i) begin
          if (bit_q == '0) phase_q <= PH_GAP;
          else begin
            phase_q <= PH_TXH;
            bit_q   <= bit_q - 1'b1;
          end
        end
        PH_GAP: if (last_i) begin
          if (rd_q) begin
            phase_q <= PH_RXH;
            bit_q   <= TOP_BIT;
          end else if (!second_q) begin
            phase_q  <= PH_TXH;
            bit_q    <= TOP_BIT;
            second_q <= 1'b1;
          end else begin
            phase_q <= PH_IDLE;
            done_o  <= 1'b1;
          end
        end
        PH_RXH: if (last_i) phase_q <= PH_RXL;
        PH_RXL: if (last_i) begin
          if (bit_q == '0) begin
            phase_q <= PH_IDLE;
            done_o  <= 1'b1;
            rdata_o <= q_i[NIB_W-1:0];
          end else begin
            phase_q <= PH_RXH;
            bit_q   <= bit_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ends_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
  assert_no_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && $past(busy_o)) |-> $stable(rd_q));
endmodule

// File: rtl/trio_nib_master.sv
module trio_nib_master
  import trio_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int HALF_NS = 700
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [NIB_W-1:0] addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NIB_W-1:0] rdata_o,
  input  logic             ce_req_i,
  output logic             ce_o,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic             sdi_i
);
  localparam int HALF_RAW = (HALF_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic              first, last, load, shift, in_bit;
  logic [BYTE_W-1:0] load_val, q;
  phase_e            phase;

  trio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(busy_o), .first_o(first), .last_o(last)
  );

  trio_shifter #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .shift_i(shift), .in_bit_i(in_bit), .q_o(q)
  );

  trio_phase_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .rd_i, .addr_i, .wdata_i,
    .last_i(last), .q_i(q), .load_o(load), .load_val_o(load_val),
    .shift_o(shift), .phase_o(phase), .busy_o, .done_o, .rdata_o
  );

  assign in_bit    = (phase == PH_RXH) ? sdi_i : 1'b0;
  assign ce_o      = ce_req_i;
  assign sclk_oe_o = 1'b1;
  assign sclk_o    = !((phase == PH_TXL) || (phase == PH_RXL));
  assign sdo_o     = q[BYTE_W-1];
  // hold the line one cycle past the final rising edge
  assign sdo_oe_o  = (phase == PH_TXH) || (phase == PH_TXL) ||
                     ((phase == PH_GAP) && first);

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o && !sdo_oe_o));
  assert_oe_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> busy_o);
  assert_tx_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && !sclk_o && $past(sdo_oe_o)) |-> $stable(sdo_o));
  always_comb assert_ce_pass_R2: assert (ce_o == ce_req_i);
endmodule

// File: tb/trio_nib_master_bench.sv
`timescale 1ns/1ps
module trio_nib_master_bench;
  localparam int CLK_MHZ = 250;
  localparam int HALF_NS = 20;
  localparam int H = (HALF_NS * CLK_MHZ + 999) / 1000;  // R11: 5 cycles

  typedef struct {
    bit sclk; bit oe; bit sdo; bit busy; bit done; bit sdi;
    bit rd_end; bit [3:0] nib; int kind;
  } ent_t;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, rd_i = 0, ce_req_i = 0, sdi_i = 0;
  logic [3:0] addr_i = 0, wdata_i = 0;
  logic busy_o, done_o, sclk_o, sclk_oe_o, sdo_o, sdo_oe_o, ce_o;
  logic [3:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  bit run_chk = 0, finished = 0;
  bit [3:0] exp_rdata = 0;
  ent_t exp_q[$];

  always #2 clk = ~clk;

  trio_nib_master #(.CLK_MHZ(CLK_MHZ), .HALF_NS(HALF_NS)) u_trio_nib_master (
    .clk_i(clk), .rst_ni, .start_i, .rd_i, .addr_i, .wdata_i,
    .busy_o, .done_o, .rdata_o, .ce_req_i, .ce_o, .sclk_o, .sclk_oe_o,
    .sdo_o, .sdo_oe_o, .sdi_i
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic ent_t mk(bit sclk, bit oe, bit sdo, bit busy, bit sdi, int kind);
    ent_t e;
    e.sclk = sclk; e.oe = oe; e.sdo = sdo; e.busy = busy; e.done = 0;
    e.sdi = sdi; e.rd_end = 0; e.nib = 0; e.kind = kind;
    return e;
  endfunction

  task automatic push_tx(input bit [7:0] b, input int kind);
    for (int k = 7; k >= 0; k--) begin
      for (int c = 0; c < H; c++) exp_q.push_back(mk(1, 1, b[k], 1, 0, kind));
      for (int c = 0; c < H; c++) exp_q.push_back(mk(0, 1, b[k], 1, 0, kind));
    end
    exp_q.push_back(mk(1, 1, b[0], 1, 0, kind));          // R7 hold cycle
    for (int c = 1; c < H; c++) exp_q.push_back(mk(1, 0, 0, 1, 0, kind)); // R8 gap
  endtask

  task automatic push_rx(input bit [7:0] r);
    for (int k = 7; k >= 0; k--) begin
      for (int c = 0; c < H; c++) exp_q.push_back(mk(1, 0, 0, 1, (c == H-1) ? r[k] : ~r[k], 2));
      for (int c = 0; c < H; c++) exp_q.push_back(mk(0, 0, 0, 1, ~r[k], 2));
    end
  endtask

  task automatic push_done(input bit rd, input bit [3:0] nib);
    ent_t e;
    e = mk(1, 0, 0, 0, 0, 3);
    e.done = 1; e.rd_end = rd; e.nib = nib;
    exp_q.push_back(e);
  endtask

  // per-cycle comparison against the queued reference
  always @(negedge clk) begin
    if (run_chk) begin
      ent_t e;
      string sreq;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = mk(1, 0, 0, 0, 0, 4);
      sdi_i = e.sdi;
      if (e.done && e.rd_end) exp_rdata = e.nib;
      case (e.kind)
        1: sreq = "R5";
        2: sreq = "R6";
        default: sreq = "R4";
      endcase
      chk(sclk_o == e.sclk, (e.kind == 2) ? "R6" : "R4", "sclk", sclk_o, e.sclk);
      chk(sdo_oe_o == e.oe, "R7", "sdo_oe", sdo_oe_o, e.oe);
      if (e.oe) chk(sdo_o == e.sdo, sreq, "sdo", sdo_o, e.sdo);
      chk(busy_o == e.busy, "R9", "busy", busy_o, e.busy);
      chk(done_o == e.done, "R9", "done", done_o, e.done);
      chk(rdata_o == exp_rdata, e.rd_end ? "R6" : "R10", "rdata", rdata_o, exp_rdata);
      chk(ce_o == ce_req_i, "R2", "ce", ce_o, ce_req_i);
      if (e.kind == 4) chk(sclk_oe_o == 1'b1, "R1", "sclk_oe idle", sclk_oe_o, 1);
    end
  end

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // write: R5 encoding, R3 mid-run requests ignored when noise is set
  task automatic do_write(input bit [3:0] a, input bit [3:0] d, input bit noise);
    @(negedge clk); #1;
    start_i = 1; rd_i = 0; addr_i = a; wdata_i = d;
    push_tx(8'h20 | {4'h0, a}, 1);
    push_tx(8'h10 | {4'h0, d}, 1);
    push_done(0, 0);
    @(negedge clk); #1;
    start_i = 0;
    if (noise) begin
      repeat (7 * H) @(negedge clk);
      #1; start_i = 1; rd_i = 1; addr_i = ~a; wdata_i = ~d;
      @(negedge clk); #1; start_i = 0;
      repeat (20 * H) @(negedge clk);
      #1; start_i = 1;
      @(negedge clk); #1; start_i = 0;
    end
    wait_idle();
  endtask

  task automatic do_read(input bit [3:0] a, input bit [7:0] resp, input bit noise);
    @(negedge clk); #1;
    start_i = 1; rd_i = 1; addr_i = a;
    push_tx(8'h60 | {4'h0, a}, 2);
    push_rx(resp);
    push_done(1, resp[3:0]);
    @(negedge clk); #1;
    start_i = 0;
    if (noise) begin
      repeat (22 * H) @(negedge clk);
      #1; start_i = 1; rd_i = 0; addr_i = ~a;
      @(negedge clk); #1; start_i = 0;
    end
    wait_idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1", "busy in reset", busy_o, 0);
    chk(done_o == 0, "R1", "done in reset", done_o, 0);
    chk(sclk_o == 1, "R1", "sclk in reset", sclk_o, 1);
    chk(sclk_oe_o == 1, "R1", "sclk_oe in reset", sclk_oe_o, 1);
    chk(sdo_oe_o == 0, "R1", "sdo_oe in reset", sdo_oe_o, 0);
    chk(rdata_o == 0, "R1", "rdata in reset", rdata_o, 0);
    #1 rst_ni = 1;
    run_chk = 1;
    repeat (3) @(negedge clk);
    ce_req_i = 1;                      // R2 driven by sequencer
    do_write(4'hE, 4'h4, 0);           // R5
    do_read(4'h0, 8'hA5, 0);           // R6 -> 5
    do_write(4'h7, 4'hF, 1);           // R3, R10 rdata held
    #1 ce_req_i = 0;
    do_read(4'hF, 8'h3C, 1);           // R3, R6 -> C
    do_read(4'h5, 8'hF0, 0);           // R6 -> 0
    do_write(4'h0, 4'h0, 0);           // R5 all-zero operands
    #1 ce_req_i = 1;
    do_read(4'hA, 8'h09, 0);           // R6 -> 9
    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule